// File: doc/BRIEF.md
# Two-Phase Configuration Scan Chain with Reset Invalidate Sequencer

This block loads per-core configuration bits serially at power-up, while no core is running. Every chain position holds two flops: a lockup flop and a config flop. Two scan-phase strobes in the same clock domain advance them. The first strobe copies each link's input into its lockup flop. The second strobe copies the lockup flop into the config flop. The source of every transfer is therefore a flop that is not written on that edge. The config flops drive the parallel configuration word seen by the core, and each one also feeds the next link. The last one drives scan-out.

Next to the chain sits a small reset sequencer. After reset it walks every cache line index once and requests an invalidate for each line, which clears that line's valid and dirty bits. The cache acknowledges each line, and the sequencer advances on each acknowledge. After the last line it raises a done flag, which stays high until the next reset.

Top module: `cfg_scan_chain`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `cfg_word` is all zeros, `scan_out` is 0, `inv_req` is 1, `inv_index` is 0 and `inv_done` is 0.
- R2: A cycle with only `ph1_en` high loads each lockup flop and leaves `cfg_word` and `scan_out` unchanged. Position 0 loads `scan_in`; position k loads config bit k-1.
- R3: A cycle with only `ph2_en` high copies every lockup flop into its config flop. After the edge, `cfg_word[0]` equals the `scan_in` captured at the last phase-1 edge, and `cfg_word[k]` equals the value `cfg_word[k-1]` had at that edge.
- R4: CHAIN_LEN alternations of phase 1 then phase 2 load CHAIN_LEN bits. The first bit shifted in ends at `cfg_word[CHAIN_LEN-1]` and the last bit at `cfg_word[0]`.
- R5: `scan_out` always equals `cfg_word[CHAIN_LEN-1]`. Further shifting presents the loaded bits at `scan_out` in the order they were shifted in.
- R6: A cycle with neither strobe high changes neither the config nor the lockup flops, whatever `scan_in` does. A phase-2 edge that follows idle cycles still delivers the value captured at the earlier phase-1 edge.
- R7: A second phase-2 edge with no phase-1 edge in between leaves `cfg_word` unchanged.
- R8: `ph1_en` and `ph2_en` are never high in the same cycle.
- R9: While walking, `inv_req` is 1. `inv_index` holds its value in cycles without `inv_ack` and goes up by one on each cycle with `inv_ack`, starting at 0. It visits every index from 0 to NUM_LINES-1 exactly once.
- R10: After the cycle in which `inv_ack` is seen at index NUM_LINES-1, `inv_done` is 1 and `inv_req` is 0 until the next reset. Further `inv_ack` pulses are ignored.
- R11: `inv_done` stays 0 until all NUM_LINES lines have been acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the chain and the sequencer |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_in | input | 1 | Serial data into chain position 0 |
| ph1_en | input | 1 | Phase-1 strobe: link inputs into lockup flops |
| ph2_en | input | 1 | Phase-2 strobe: lockup flops into config flops |
| inv_ack | input | 1 | Cache acknowledge for the current invalidate request |
| cfg_word | output | CHAIN_LEN | Parallel configuration bits seen by the core |
| scan_out | output | 1 | Serial data out of the last config flop |
| inv_req | output | 1 | Invalidate request for line `inv_index` |
| inv_index | output | $clog2(NUM_LINES) | Cache line index being invalidated |
| inv_done | output | 1 | High once every line has been invalidated |

## Verification
A lockup or config flop holding the wrong value shows up on `cfg_word` at the next phase-2 edge. That bit then moves one position per phase pair and reaches `scan_out` after at most CHAIN_LEN pairs. For this reason the bench checks the whole word after every strobe, not only the word at the end of a load. A wrong sequencer index or state shows up on `inv_index`, `inv_req` or `inv_done` one cycle after the acknowledge that caused it. A skipped, repeated or early-finishing walk is therefore seen within the walk itself.

// File: rtl/cfg_scan_pkg.sv
package cfg_scan_pkg;

    // State of one chain position: lockup flop and config flop.
    typedef struct packed {
        logic lock;
        logic cfg;
    } link_t;

    // Reset invalidate sequencer states.
    typedef enum logic {
        INV_WALK = 1'b0,
        INV_DONE = 1'b1
    } inv_state_e;

endpackage

// File: rtl/cfg_scan_link.sv
module cfg_scan_link
    import cfg_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ph1_en,
    input  logic ph2_en,
    input  logic link_in,
    output logic cfg_bit
);

    link_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Phase 1 writes only the lockup flop; its source is never written on this edge.
        if (ph1_en) st_d.lock = link_in;
        // Phase 2 writes only the config flop from the lockup flop.
        if (ph2_en) st_d.cfg  = st_q.lock;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_bit = st_q.cfg;

endmodule

// File: rtl/cfg_inv_seq.sv
module cfg_inv_seq
    import cfg_scan_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_ack,
    output logic             inv_req,
    output logic [IDX_W-1:0] inv_index,
    output logic             inv_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    typedef struct packed {
        inv_state_e       st;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.st == INV_WALK && inv_ack) begin
            if (seq_q.idx == LAST_IDX) seq_d.st  = INV_DONE;
            else                       seq_d.idx = seq_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: INV_WALK, idx: '0};
        else        seq_q <= seq_d;
    end

    assign inv_req   = (seq_q.st == INV_WALK);
    assign inv_done  = (seq_q.st == INV_DONE);
    assign inv_index = seq_q.idx;

endmodule

// File: rtl/cfg_scan_chain.sv
module cfg_scan_chain #(
    parameter int CHAIN_LEN = 16,
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_in,
    input  logic                 ph1_en,
    input  logic                 ph2_en,
    input  logic                 inv_ack,
    output logic [CHAIN_LEN-1:0] cfg_word,
    output logic                 scan_out,
    output logic                 inv_req,
    output logic [IDX_W-1:0]     inv_index,
    output logic                 inv_done
);

    logic [CHAIN_LEN-1:0] link_in;

    for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_link
        if (k == 0) begin : g_head
            assign link_in[k] = scan_in;
        end else begin : g_body
            assign link_in[k] = cfg_word[k-1];
        end

        cfg_scan_link u_link (
            .clk     (clk),
            .rst_n   (rst_n),
            .ph1_en  (ph1_en),
            .ph2_en  (ph2_en),
            .link_in (link_in[k]),
            .cfg_bit (cfg_word[k])
        );
    end

    assign scan_out = cfg_word[CHAIN_LEN-1];

    cfg_inv_seq #(.NUM_LINES(NUM_LINES)) u_inv (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_ack   (inv_ack),
        .inv_req   (inv_req),
        .inv_index (inv_index),
        .inv_done  (inv_done)
    );

endmodule

// File: rtl/cfg_scan_chain_chk.sv
module cfg_scan_chain_chk #(
    parameter int CHAIN_LEN = 16,
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ph1_en,
    input logic                 ph2_en,
    input logic                 inv_ack,
    input logic [CHAIN_LEN-1:0] cfg_word,
    input logic                 inv_req,
    input logic [IDX_W-1:0]     inv_index,
    input logic                 inv_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    assert_one_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph1_en && ph2_en));

    assert_ph1_keeps_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1_en && !ph2_en) |=> $stable(cfg_word));

    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ph1_en && !ph2_en) |=> $stable(cfg_word));

    assert_walk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !inv_ack) |=> (inv_req && $stable(inv_index)));

    assert_walk_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && inv_ack && inv_index != LAST_IDX) |=>
            (inv_req && inv_index == $past(inv_index) + 1'b1));

    assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && inv_ack && inv_index == LAST_IDX) |=> inv_done);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> (inv_done && !inv_req));

    assert_req_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_done && inv_req));

endmodule

bind cfg_scan_chain cfg_scan_chain_chk #(
    .CHAIN_LEN (CHAIN_LEN),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph1_en    (ph1_en),
    .ph2_en    (ph2_en),
    .inv_ack   (inv_ack),
    .cfg_word  (cfg_word),
    .inv_req   (inv_req),
    .inv_index (inv_index),
    .inv_done  (inv_done)
);

// File: tb/cfg_scan_chain_tb.sv
module cfg_scan_chain_tb;

    localparam int N     = 16;
    localparam int LINES = 8;
    localparam int IW    = $clog2(LINES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_in = 1'b0;
    logic          ph1_en = 1'b0;
    logic          ph2_en = 1'b0;
    logic          inv_ack = 1'b0;
    logic [N-1:0]  cfg_word;
    logic          scan_out;
    logic          inv_req;
    logic [IW-1:0] inv_index;
    logic          inv_done;

    always #10 clk = ~clk;

    cfg_scan_chain #(.CHAIN_LEN(N), .NUM_LINES(LINES)) u_dut (
        .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .ph1_en(ph1_en),
        .ph2_en(ph2_en), .inv_ack(inv_ack), .cfg_word(cfg_word),
        .scan_out(scan_out), .inv_req(inv_req), .inv_index(inv_index),
        .inv_done(inv_done)
    );

    // kind 0: scan chain, kind 1: sequencer, kind 2: everything
    typedef struct {
        int            kind;
        logic [N-1:0]  cfg;
        logic          so;
        logic          req;
        logic [IW-1:0] idx;
        logic          done;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    // Reference state built from the requirements.
    logic [N-1:0]  m_lock, m_cfg;
    logic [IW-1:0] m_idx;
    logic          m_done;

    function automatic void push(int kind, string tag);
        exp_t e;
        e.kind = kind;
        e.cfg  = m_cfg;
        e.so   = m_cfg[N-1];
        e.req  = !m_done;
        e.idx  = m_idx;
        e.done = m_done;
        e.tag  = tag;
        exp_q.push_back(e);
    endfunction

    // Monitor: compares each expected item with the outputs at the falling edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (e.kind != 1 && (cfg_word !== e.cfg || scan_out !== e.so)) begin
                errors++;
                $display("FAIL %s: cfg_word=%h scan_out=%b expected cfg_word=%h scan_out=%b",
                         e.tag, cfg_word, scan_out, e.cfg, e.so);
            end else if (e.kind != 0 &&
                         (inv_req !== e.req || inv_done !== e.done ||
                          (e.req && inv_index !== e.idx))) begin
                errors++;
                $display("FAIL %s: req=%b idx=%0d done=%b expected req=%b idx=%0d done=%b",
                         e.tag, inv_req, inv_index, inv_done, e.req, e.idx, e.done);
            end
        end
    end

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0; ph1_en = 1'b0; ph2_en = 1'b0; inv_ack = 1'b0;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        m_lock = '0; m_cfg = '0; m_idx = '0; m_done = 1'b0;
        @(posedge clk); #1;
        push(2, tag);
    endtask

    task automatic scan_op(logic p1, logic p2, logic sin, string tag);
        logic [N-1:0] nl, nc;
        @(negedge clk);
        ph1_en = p1; ph2_en = p2; scan_in = sin;
        @(posedge clk);
        nl = p1 ? {m_cfg[N-2:0], sin} : m_lock;
        nc = p2 ? m_lock : m_cfg;
        m_lock = nl; m_cfg = nc;
        #1;
        push(0, tag);
    endtask

    task automatic inv_op(logic ack, string tag);
        @(negedge clk);
        inv_ack = ack;
        @(posedge clk);
        if (ack && !m_done) begin
            if (m_idx == IW'(LINES - 1)) m_done = 1'b1;
            else                         m_idx  = m_idx + 1'b1;
        end
        #1;
        push(1, tag);
    endtask

    initial begin
        logic [N-1:0] pat;
        logic [N-1:0] got_out;
        pat = 16'hA5C3;

        do_reset("R1 reset state");

        // R2 / R3 / R7: single bit
        scan_op(1'b1, 1'b0, 1'b1, "R2 phase1 only keeps cfg");
        scan_op(1'b0, 1'b1, 1'b0, "R3 phase2 moves lockup to cfg");
        scan_op(1'b0, 1'b1, 1'b1, "R7 repeated phase2 no change");
        // R6: idle cycles with scan_in toggling
        scan_op(1'b0, 1'b0, 1'b0, "R6 idle hold");
        scan_op(1'b0, 1'b0, 1'b1, "R6 idle hold toggling scan_in");
        // R6: lockup survives idle cycles before phase 2
        scan_op(1'b1, 1'b0, 1'b0, "R2 capture before idle gap");
        scan_op(1'b0, 1'b0, 1'b1, "R6 idle with pending lockup");
        scan_op(1'b0, 1'b0, 1'b1, "R6 idle with pending lockup");
        scan_op(1'b0, 1'b1, 1'b1, "R6 phase2 after idle gap");

        // R4: full load from reset, first bit ends at the top
        do_reset("R1 reset clears chain");
        for (int i = 0; i < N; i++) begin
            scan_op(1'b1, 1'b0, pat[N-1-i], "R2 load phase1");
            scan_op(1'b0, 1'b1, ~pat[N-1-i], "R4 load phase2");
        end
        // first shifted bit is pat[N-1] -> cfg_word[N-1]; so word equals pat
        @(negedge clk); #1;
        checks++;
        if (cfg_word !== pat) begin
            errors++;
            $display("FAIL R4 full load: cfg_word=%h expected %h", cfg_word, pat);
        end

        // R5: shift out, bits appear in shift-in order
        got_out = '0;
        for (int i = 0; i < N; i++) begin
            got_out[N-1-i] = scan_out;
            scan_op(1'b1, 1'b0, 1'b0, "R5 unload phase1");
            scan_op(1'b0, 1'b1, 1'b0, "R5 unload phase2");
        end
        checks++;
        if (got_out !== pat) begin
            errors++;
            $display("FAIL R5 scan_out order: got %h expected %h", got_out, pat);
        end

        // R9 / R11: walk with gaps between acknowledges
        do_reset("R1 sequencer reset");
        for (int i = 0; i < LINES; i++) begin
            inv_op(1'b0, "R9 index holds without ack");
            inv_op(1'b1, (i == LINES - 1) ? "R10 done after last ack" : "R11 step, not done");
        end
        // R10: further acks ignored, done sticky
        inv_op(1'b1, "R10 extra ack ignored");
        inv_op(1'b0, "R10 done holds");
        inv_op(1'b1, "R10 extra ack ignored");
        do_reset("R1 reset clears done");
        // back-to-back acks
        for (int i = 0; i < LINES; i++) inv_op(1'b1, "R9 back-to-back acks");
        inv_op(1'b0, "R10 done after walk");

        @(negedge clk); @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule